// File: doc/BRIEF.md
# Shadowed Byte Memory with Row-Parallel Bulk Transfer

The block is a 512-byte synchronous working memory paired with a shadow array of the same size. The shadow array stands in for nonvolatile cells and is modelled as plain registers. A single-byte port reads and writes the working array. Software or a system controller can request a bulk transfer in one of two directions. A store saves the working array into the shadow array. A recall brings the saved image back into the working array.

Both arrays are organised as 16 rows of 32 bytes. A transfer moves one whole row per clock and runs in two phases. A store first erases a shadow row and then programs it from the working array. A recall first clears the working rows and then loads them from the shadow array. While a transfer runs, the block raises a busy flag and locks out the byte port. A one-clock done pulse closes each transfer. An internal counter records completed stores for wear accounting.

Top module: `shadow_ram`

## Requirements
- R1: After reset, busy, done and rdValid are low, rdData is zero, and every byte of both arrays reads as zero.
- R2: A write with wrEn high and busy low stores wrData at addr. A read with rdEn high and busy low drives that byte on rdData with rdValid high in the next cycle. addr[8:5] selects the row and addr[4:0] selects the column.
- R3: When rdEn and wrEn are both high in one cycle, the read returns the byte held before that write.
- R4: Whenever rdValid is low, rdData is zero.
- R5: xferStart sampled high while busy is low begins a transfer. xferDir 0 selects store and 1 selects recall. Busy is high from the next cycle on, and done is high for exactly one cycle, 33 cycles after the start edge. Busy falls in the cycle after done.
- R6: A store leaves the shadow array equal to the working array as it stood at the start, and leaves the working array unchanged.
- R7: A recall leaves the working array equal to the shadow array, which replaces every byte written since the last store.
- R8: A recall never changes the shadow array, so repeated recalls each restore the same image.
- R9: While busy is high, byte writes are dropped and byte reads are refused, so rdValid stays low and rdData stays zero.
- R10: A start request while busy is ignored. The running transfer keeps its direction and its timing, and no second transfer follows.
- R11: Each completed store advances an internal wear count by one, modulo 2^WEAR_W. Rollover of this count has no effect on port behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rdEn | input | 1 | Byte read request |
| wrEn | input | 1 | Byte write request |
| addr | input | 9 | Byte address (row in the upper 4 bits, column in the lower 5) |
| wrData | input | 8 | Byte write data |
| rdData | output | 8 | Registered read data, zero when not valid |
| rdValid | output | 1 | rdData carries an accepted read |
| xferStart | input | 1 | Request a bulk transfer |
| xferDir | input | 1 | Transfer direction: 0 store, 1 recall |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse that ends a transfer |

## Verification
A read result is due one clock after the edge that samples rdEn, so the bench drives a request on a falling edge and checks rdData on the next falling edge. For a transfer, busy is due one edge after the start, done 33 edges after it, and busy low one edge after done. The bench counts falling edges from the start and checks done at each of them, so an early, late or doubled pulse is caught. The effect of a transfer on the arrays appears only after done. The bench checks it with full sweeps of the working array, and it observes shadow contents through a later recall.

// File: rtl/shadow_ram_pkg.sv
package shadow_ram_pkg;
  parameter int DATA_W = 8;
  parameter int ROW_W = 4;
  parameter int COL_W = 5;
  localparam int NUM_ROWS = 1 << ROW_W;
  localparam int NUM_COLS = 1 << COL_W;
  localparam int ADDR_W = ROW_W + COL_W;

  typedef enum logic [1:0] {
    XF_IDLE   = 2'd0,
    XF_FIRST  = 2'd1,
    XF_SECOND = 2'd2,
    XF_FINISH = 2'd3
  } xferState_t;

  typedef struct packed {
    logic             byteRead;
    logic             byteWrite;
    logic             clearWork;
    logic             loadWork;
    logic             eraseShadow;
    logic             programShadow;
    logic [ROW_W-1:0] row;
  } dpStrobe_t;
endpackage

// File: rtl/shadow_ram_ctrl.sv
module shadow_ram_ctrl
  import shadow_ram_pkg::*;
#(
  parameter int WEAR_W = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rdEn,
  input  logic      wrEn,
  input  logic      xferStart,
  input  logic      xferDir,
  output logic      busy,
  output logic      done,
  output dpStrobe_t strobe
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  xferState_t       state;
  logic [ROW_W-1:0] rowCnt;
  logic             isRecall;
  logic [WEAR_W-1:0] wearCnt;

  always_comb begin
    busy = (state != XF_IDLE);
    done = (state == XF_FINISH);
    strobe.byteRead      = rdEn & ~busy;
    strobe.byteWrite     = wrEn & ~busy;
    strobe.clearWork     = (state == XF_FIRST) & isRecall;
    strobe.loadWork      = (state == XF_SECOND) & isRecall;
    strobe.eraseShadow   = (state == XF_FIRST) & ~isRecall;
    strobe.programShadow = (state == XF_SECOND) & ~isRecall;
    strobe.row           = rowCnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= XF_IDLE;
      rowCnt   <= '0;
      isRecall <= 1'b0;
      wearCnt  <= '0;
    end else begin
      unique case (state)
        XF_IDLE: begin
          if (xferStart) begin
            state    <= XF_FIRST;
            isRecall <= xferDir;
            rowCnt   <= '0;
          end
        end
        XF_FIRST: begin
          rowCnt <= rowCnt + 1'b1;
          if (rowCnt == LAST_ROW) state <= XF_SECOND;
        end
        XF_SECOND: begin
          rowCnt <= rowCnt + 1'b1;
          if (rowCnt == LAST_ROW) state <= XF_FINISH;
        end
        XF_FINISH: begin
          state <= XF_IDLE;
          if (!isRecall) wearCnt <= wearCnt + 1'b1;
        end
        default: state <= XF_IDLE;
      endcase
    end
  end

  // R5: done lasts a single cycle and busy is released right after it
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R5: done only occurs while busy
  p_done_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R10: a running transfer is not cut short and keeps its direction
  p_keep_running_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(isRecall)));
  // R5: the first phase hands over to the second after the last row
  p_phase_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XF_FIRST && rowCnt == LAST_ROW) |=> (state == XF_SECOND && rowCnt == '0));
  // R11: each finished store advances the wear count by one, modulo its width
  p_wear_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !isRecall) |=> (wearCnt == WEAR_W'($past(wearCnt) + 1'b1)));
  // R9: no byte access is granted during a transfer
  p_port_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(strobe.byteRead || strobe.byteWrite));
endmodule

// File: rtl/shadow_ram_dp.sv
module shadow_ram_dp
  import shadow_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] workMem   [NUM_ROWS][NUM_COLS];
  logic [DATA_W-1:0] shadowMem [NUM_ROWS][NUM_COLS];
  logic [ROW_W-1:0]  addrRow;
  logic [COL_W-1:0]  addrCol;

  assign addrRow = addr[ADDR_W-1:COL_W];
  assign addrCol = addr[COL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      for (int r = 0; r < NUM_ROWS; r++) begin
        for (int c = 0; c < NUM_COLS; c++) begin
          workMem[r][c] <= '0;
        end
      end
    end else begin
      rdValid <= strobe.byteRead;
      rdData  <= strobe.byteRead ? workMem[addrRow][addrCol] : '0;
      if (strobe.byteWrite) workMem[addrRow][addrCol] <= wrData;
      for (int c = 0; c < NUM_COLS; c++) begin
        if (strobe.clearWork) workMem[strobe.row][c] <= '0;
        if (strobe.loadWork)  workMem[strobe.row][c] <= shadowMem[strobe.row][c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        for (int c = 0; c < NUM_COLS; c++) begin
          shadowMem[r][c] <= '0;
        end
      end
    end else begin
      for (int c = 0; c < NUM_COLS; c++) begin
        if (strobe.eraseShadow)   shadowMem[strobe.row][c] <= '0;
        if (strobe.programShadow) shadowMem[strobe.row][c] <= workMem[strobe.row][c];
      end
    end
  end

  // R4: the output bus is quiet whenever no read result is presented
  p_quiet_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rdValid |-> (rdData == '0));
  // R2: a read result appears exactly one cycle after its request
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.byteRead |=> rdValid);
  // R9: a row step never coincides with a byte access
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.clearWork || strobe.loadWork || strobe.eraseShadow || strobe.programShadow)
      |-> !(strobe.byteWrite || strobe.byteRead));
endmodule

// File: rtl/shadow_ram.sv
module shadow_ram
  import shadow_ram_pkg::*;
#(
  parameter int WEAR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic              xferStart,
  input  logic              xferDir,
  output logic              busy,
  output logic              done
);
  dpStrobe_t strobe;

  shadow_ram_ctrl #(.WEAR_W(WEAR_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .xferStart(xferStart),
    .xferDir  (xferDir),
    .busy     (busy),
    .done     (done),
    .strobe   (strobe)
  );

  shadow_ram_dp dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .rdValid(rdValid)
  );

  // R9: a byte read accepted while idle is never followed by a read result during a later lock
  p_no_result_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> !rdValid);
endmodule

// File: tb/shadow_ram_tb.sv
module shadow_ram_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       rdValid;
  logic       xferStart = 1'b0;
  logic       xferDir = 1'b0;
  logic       busy;
  logic       done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [7:0] workM [512];
  logic [7:0] shadM [512];

  always #10 clk = ~clk;

  shadow_ram #(.WEAR_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .xferStart(xferStart), .xferDir(xferDir), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = 9'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    workM[a] = d;
  endtask

  task automatic doRead(input int a, input string req);
    @(negedge clk);
    rdEn = 1'b1; addr = 9'(a);
    @(negedge clk);
    rdEn = 1'b0;
    chk(rdValid == 1'b1 && rdData == workM[a], req, "read data", int'(rdData), int'(workM[a]));
  endtask

  task automatic sweep(input string req);
    int bad = 0;
    int firstAct = 0;
    int firstExp = 0;
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      rdEn = 1'b1; addr = 9'(a);
      @(negedge clk);
      rdEn = 1'b0;
      if (!(rdValid && rdData == workM[a])) begin
        if (bad == 0) begin firstAct = int'(rdData); firstExp = int'(workM[a]); end
        bad++;
      end
    end
    chk(bad == 0, req, "array sweep first mismatch", firstAct, firstExp);
  endtask

  task automatic randomFill(input int n);
    for (int i = 0; i < n; i++) doWrite(int'($urandom_range(511)), 8'($urandom));
  endtask

  task automatic runXfer(input logic dir, input bit disturb, input string req);
    int doneSeen = 0;
    bit timingOk = 1'b1;
    bit lockOk = 1'b1;
    @(negedge clk);
    xferStart = 1'b1; xferDir = dir;
    @(negedge clk);
    xferStart = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R5", "busy one edge after start", int'(busy), 1);
    for (int i = 1; i <= 32; i++) begin
      if (disturb && i == 5) begin
        wrEn = 1'b1; rdEn = 1'b1; addr = 9'd77; wrData = ~workM[77];
        xferStart = 1'b1; xferDir = ~dir;
      end
      @(negedge clk);
      wrEn = 1'b0; rdEn = 1'b0; xferStart = 1'b0;
      if (rdValid !== 1'b0 || rdData !== 8'd0) lockOk = 1'b0;
      if (done) doneSeen++;
      if (i < 32 && (done || !busy)) timingOk = 1'b0;
      if (i == 32 && !(done && busy)) timingOk = 1'b0;
    end
    chk(timingOk && doneSeen == 1, req, "done 33 edges after start", doneSeen, 1);
    chk(lockOk, "R9", "no read result during transfer", int'(lockOk), 1);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, req, "busy low after done", int'(busy), 0);
    if (disturb) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (busy) timingOk = 1'b0;
      end
      chk(timingOk, "R10", "no second transfer after ignored start", int'(busy), 0);
    end
    if (dir) workM = shadM;
    else shadM = workM;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int a = 0; a < 512; a++) begin workM[a] = 8'd0; shadM[a] = 8'd0; end
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && rdValid == 0 && rdData == 0, "R1", "outputs in reset",
        int'({busy, done, rdValid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && rdValid == 0 && rdData == 0, "R1", "outputs after reset", int'(rdData), 0);
    sweep("R1");
    runXfer(1'b1, 1'b0, "R1");
    sweep("R1");

    randomFill(300);
    for (int i = 0; i < 60; i++) doRead(int'($urandom_range(511)), "R2");
    doWrite(0, 8'hA5); doWrite(511, 8'h3C); doWrite(31, 8'h81); doWrite(32, 8'h18);
    doRead(0, "R2"); doRead(511, "R2"); doRead(31, "R2"); doRead(32, "R2");

    // R3: read and write in the same cycle return the old byte
    @(negedge clk);
    rdEn = 1'b1; wrEn = 1'b1; addr = 9'd200; wrData = ~workM[200];
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    chk(rdValid && rdData == workM[200], "R3", "read before write", int'(rdData), int'(workM[200]));
    workM[200] = wrData;
    doRead(200, "R3");

    // R4: quiet bus when not reading
    @(negedge clk);
    chk(rdValid == 0 && rdData == 0, "R4", "rdData zero when idle", int'(rdData), 0);

    sweep("R2");
    runXfer(1'b0, 1'b0, "R5");
    sweep("R6");

    randomFill(200);
    runXfer(1'b1, 1'b0, "R5");
    sweep("R7");

    randomFill(150);
    runXfer(1'b1, 1'b0, "R5");
    sweep("R8");

    randomFill(100);
    runXfer(1'b0, 1'b1, "R10");
    sweep("R9");
    randomFill(80);
    runXfer(1'b1, 1'b0, "R10");
    sweep("R10");

    for (int k = 0; k < 4; k++) begin
      randomFill(20);
      runXfer(1'b0, 1'b0, "R11");
    end
    randomFill(50);
    runXfer(1'b1, 1'b0, "R11");
    sweep("R11");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule